// File: doc/BRIEF.md
# Test-Port Instruction and Data-Register Unit

This block is the instruction-driven half of a boundary-scan test port. A separate TAP state machine supplies one-cycle state strobes (test-logic-reset, capture-DR, shift-DR, update-DR, update-IR) and the instruction code it has shifted in. From these the unit keeps the active instruction and picks one of three data registers for the scan path: a one-bit bypass stage, a 32-bit identification register, or a boundary register with one cell per pin. It drives the serial output and, for every pin, the value and enable that reach the pad.

During normal operation each pin carries the core's own value and enable. The test instructions can sample the pads, drive them from the boundary register's parallel stage, hold them at that stage's value, or float them. The identification word holds a revision field, a device field that names how many channels the part has (one to four), and a fixed manufacturer field.

Top module: `jtag_dr_unit`

## Requirements
- R1: The instruction code is 3 bits: 000 EXTEST, 001 SAMPLE/PRELOAD, 010 IDCODE, 011 HIGHZ, 100 CLAMP, 111 BYPASS. Codes 101 and 110 act as BYPASS. A new code takes effect only at the rising TCK edge on which update_ir_i is high.
- R2: Under SAMPLE/PRELOAD, capture loads pin_in_i into the boundary shift stage. Each shift cycle moves tdi_i into the top cell (pin NUM_PINS-1) while cell 0 feeds TDO. The pins keep the core value and enable.
- R3: Under EXTEST, every pin_oe_o is 1 and pin_val_o equals the boundary parallel stage. Capture loads pin_in_i.
- R4: Under BYPASS and the undefined codes, capture clears the bypass bit, and tdi_i reaches TDO one shift cycle later. The pins keep the core value and enable.
- R5: Under IDCODE, capture loads the ID word, which then leaves on TDO least significant bit first.
- R6: Test-logic-reset or rst_ni makes IDCODE active and clears the boundary parallel stage to zero.
- R7: Under HIGHZ, every pin_oe_o is 0, and the bypass bit forms the scan path.
- R8: Under CLAMP, every pin_oe_o is 1, pin_val_o is the boundary parallel stage and stays constant, and the bypass bit forms the scan path.
- R9: The ID word has REVISION in bits 31:28, 0x002B+CHANNELS in bits 27:12 (0x002C for one channel up to 0x002F for four), 00010100001 in bits 11:1, and 1 in bit 0.
- R10: The boundary parallel stage copies the shift stage only on update-DR while SAMPLE/PRELOAD or EXTEST is active. It holds at all other times apart from R6.
- R11: tdo_o changes on the falling TCK edge to cell 0 of the selected register. tdo_oe_o is 1 exactly while shift_dr_i is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck_i | input | 1 | Test clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tlr_i | input | 1 | TAP is in test-logic-reset |
| capture_dr_i | input | 1 | TAP is in capture-DR |
| shift_dr_i | input | 1 | TAP is in shift-DR |
| update_dr_i | input | 1 | TAP is in update-DR |
| update_ir_i | input | 1 | TAP is in update-IR |
| instr_i | input | 3 | Shifted-in instruction code |
| tdi_i | input | 1 | Serial test data in |
| tdo_o | output | 1 | Serial test data out |
| tdo_oe_o | output | 1 | Enable for the serial output driver |
| core_val_i | input | NUM_PINS | Core value for each pin |
| core_oe_i | input | NUM_PINS | Core output enable for each pin |
| pin_in_i | input | NUM_PINS | Value seen at each pad |
| pin_val_o | output | NUM_PINS | Value driven to each pad |
| pin_oe_o | output | NUM_PINS | Output enable for each pad |

## Verification
The assertions assume the state strobes come from a legal TAP walk: no more than one strobe is high in any cycle, and tlr_i is never high together with another strobe. The bench keeps to this by modelling the TAP sequence in tasks that raise one strobe per cycle, with idle cycles between the instruction load and every data scan. It changes the core inputs in every cycle, because the pin overrides must hold no matter what the core drives.

// File: rtl/jtag_dr_pkg.sv
`timescale 1ns/1ps
package jtag_dr_pkg;
  typedef enum logic [2:0] {
    OP_EXTEST = 3'b000,
    OP_SAMPLE = 3'b001,
    OP_IDCODE = 3'b010,
    OP_HIGHZ  = 3'b011,
    OP_CLAMP  = 3'b100,
    OP_BYPASS = 3'b111
  } op_e;

  localparam logic [10:0] MFR_CODE = 11'b00010100001;

  // undefined codes fold onto bypass
  function automatic op_e op_norm(input logic [2:0] code);
    case (code)
      3'b000:  return OP_EXTEST;
      3'b001:  return OP_SAMPLE;
      3'b010:  return OP_IDCODE;
      3'b011:  return OP_HIGHZ;
      3'b100:  return OP_CLAMP;
      default: return OP_BYPASS;
    endcase
  endfunction
endpackage

// File: rtl/jtag_ir_dec.sv
`timescale 1ns/1ps
module jtag_ir_dec
  import jtag_dr_pkg::*;
(
  input  logic       tck_i,
  input  logic       rst_ni,
  input  logic       tlr_i,
  input  logic       update_ir_i,
  input  logic [2:0] instr_i,
  output op_e        active_o,
  output logic       sel_bsr_o,
  output logic       sel_id_o,
  output logic       sel_byp_o,
  output logic       drive_bsr_o,
  output logic       hiz_o
);
  op_e act_q;

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni)          act_q <= OP_IDCODE;
    else if (tlr_i)       act_q <= OP_IDCODE;
    else if (update_ir_i) act_q <= op_norm(instr_i);
  end

  always_comb begin
    sel_bsr_o   = (act_q == OP_SAMPLE) || (act_q == OP_EXTEST);
    sel_id_o    = (act_q == OP_IDCODE);
    sel_byp_o   = !sel_bsr_o && !sel_id_o;
    drive_bsr_o = (act_q == OP_EXTEST) || (act_q == OP_CLAMP);
    hiz_o       = (act_q == OP_HIGHZ);
  end

  assign active_o = act_q;

  p_tlr_idcode_r6: assert property (@(posedge tck_i) disable iff (!rst_ni)
    tlr_i |=> (active_o == OP_IDCODE));
  p_ir_hold_r1: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (!tlr_i && !update_ir_i) |=> $stable(active_o));
endmodule

// File: rtl/jtag_id_byp.sv
`timescale 1ns/1ps
module jtag_id_byp #(
  parameter logic [31:0] ID_WORD = 32'h0
) (
  input  logic tck_i,
  input  logic rst_ni,
  input  logic sel_id_i,
  input  logic sel_byp_i,
  input  logic capture_dr_i,
  input  logic shift_dr_i,
  input  logic tdi_i,
  output logic id_lsb_o,
  output logic byp_o
);
  logic [31:0] id_sr;
  logic        byp_q;

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni) id_sr <= ID_WORD;
    else if (sel_id_i && capture_dr_i) id_sr <= ID_WORD;
    else if (sel_id_i && shift_dr_i)   id_sr <= {tdi_i, id_sr[31:1]};
  end

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni) byp_q <= 1'b0;
    else if (sel_byp_i && capture_dr_i) byp_q <= 1'b0;
    else if (sel_byp_i && shift_dr_i)   byp_q <= tdi_i;
  end

  assign id_lsb_o = id_sr[0];
  assign byp_o    = byp_q;

  p_id_capture_r5: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (sel_id_i && capture_dr_i) |=> (id_sr == ID_WORD));
  p_byp_capture_r4: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (sel_byp_i && capture_dr_i) |=> !byp_o);
endmodule

// File: rtl/jtag_bsr.sv
`timescale 1ns/1ps
module jtag_bsr #(
  parameter int NUM_PINS = 8
) (
  input  logic                tck_i,
  input  logic                rst_ni,
  input  logic                tlr_i,
  input  logic                sel_i,
  input  logic                capture_dr_i,
  input  logic                shift_dr_i,
  input  logic                update_dr_i,
  input  logic                tdi_i,
  input  logic [NUM_PINS-1:0] pin_in_i,
  output logic                lsb_o,
  output logic [NUM_PINS-1:0] upd_o
);
  localparam int TOP = NUM_PINS - 1;

  logic [NUM_PINS-1:0] sr_q, upd_q;
  logic [NUM_PINS:0]   chain;

  assign chain[NUM_PINS] = tdi_i;

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_cell
    assign chain[i] = sr_q[i];

    always_ff @(posedge tck_i or negedge rst_ni) begin
      if (!rst_ni) sr_q[i] <= 1'b0;
      else if (sel_i && capture_dr_i) sr_q[i] <= pin_in_i[i];
      else if (sel_i && shift_dr_i)   sr_q[i] <= chain[i+1];
    end

    always_ff @(posedge tck_i or negedge rst_ni) begin
      if (!rst_ni)                    upd_q[i] <= 1'b0;
      else if (tlr_i)                 upd_q[i] <= 1'b0;
      else if (sel_i && update_dr_i)  upd_q[i] <= sr_q[i];
    end
  end

  assign lsb_o = sr_q[0];
  assign upd_o = upd_q;

  p_upd_hold_r10: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (!update_dr_i && !tlr_i) |=> $stable(upd_o));
  p_upd_clear_r6: assert property (@(posedge tck_i) disable iff (!rst_ni)
    tlr_i |=> (upd_o == '0));
  p_shift_in_r2: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (sel_i && shift_dr_i && !capture_dr_i) |=> (sr_q[TOP] == $past(tdi_i)));
endmodule

// File: rtl/jtag_dr_unit.sv
`timescale 1ns/1ps
module jtag_dr_unit
  import jtag_dr_pkg::*;
#(
  parameter int          NUM_PINS = 8,
  parameter int          CHANNELS = 4,
  parameter logic [3:0]  REVISION = 4'h1
) (
  input  logic                tck_i,
  input  logic                rst_ni,
  input  logic                tlr_i,
  input  logic                capture_dr_i,
  input  logic                shift_dr_i,
  input  logic                update_dr_i,
  input  logic                update_ir_i,
  input  logic [2:0]          instr_i,
  input  logic                tdi_i,
  output logic                tdo_o,
  output logic                tdo_oe_o,
  input  logic [NUM_PINS-1:0] core_val_i,
  input  logic [NUM_PINS-1:0] core_oe_i,
  input  logic [NUM_PINS-1:0] pin_in_i,
  output logic [NUM_PINS-1:0] pin_val_o,
  output logic [NUM_PINS-1:0] pin_oe_o
);
  localparam logic [15:0] DEV_CODE = 16'h002B + 16'(CHANNELS);
  localparam logic [31:0] ID_WORD  = {REVISION, DEV_CODE, MFR_CODE, 1'b1};

  op_e                 active;
  logic                sel_bsr, sel_id, sel_byp, drive_bsr, hiz;
  logic                id_lsb, byp_bit, bsr_lsb, tdo_d;
  logic [NUM_PINS-1:0] bsr_upd;

  jtag_ir_dec u_dec (
    .tck_i       (tck_i),
    .rst_ni      (rst_ni),
    .tlr_i       (tlr_i),
    .update_ir_i (update_ir_i),
    .instr_i     (instr_i),
    .active_o    (active),
    .sel_bsr_o   (sel_bsr),
    .sel_id_o    (sel_id),
    .sel_byp_o   (sel_byp),
    .drive_bsr_o (drive_bsr),
    .hiz_o       (hiz)
  );

  jtag_id_byp #(.ID_WORD(ID_WORD)) u_idb (
    .tck_i        (tck_i),
    .rst_ni       (rst_ni),
    .sel_id_i     (sel_id),
    .sel_byp_i    (sel_byp),
    .capture_dr_i (capture_dr_i),
    .shift_dr_i   (shift_dr_i),
    .tdi_i        (tdi_i),
    .id_lsb_o     (id_lsb),
    .byp_o        (byp_bit)
  );

  jtag_bsr #(.NUM_PINS(NUM_PINS)) u_bsr (
    .tck_i        (tck_i),
    .rst_ni       (rst_ni),
    .tlr_i        (tlr_i),
    .sel_i        (sel_bsr),
    .capture_dr_i (capture_dr_i),
    .shift_dr_i   (shift_dr_i),
    .update_dr_i  (update_dr_i),
    .tdi_i        (tdi_i),
    .pin_in_i     (pin_in_i),
    .lsb_o        (bsr_lsb),
    .upd_o        (bsr_upd)
  );

  always_comb begin
    if (sel_bsr)     tdo_d = bsr_lsb;
    else if (sel_id) tdo_d = id_lsb;
    else             tdo_d = byp_bit;
  end

  // serial output moves on the falling edge
  always_ff @(negedge tck_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tdo_o    <= 1'b0;
      tdo_oe_o <= 1'b0;
    end else begin
      tdo_o    <= tdo_d;
      tdo_oe_o <= shift_dr_i;
    end
  end

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    assign pin_val_o[i] = drive_bsr ? bsr_upd[i] : core_val_i[i];
    assign pin_oe_o[i]  = hiz ? 1'b0 : (drive_bsr ? 1'b1 : core_oe_i[i]);
  end

  p_extest_drive_r3: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (active == OP_EXTEST) |-> (&pin_oe_o && pin_val_o == bsr_upd));
  p_highz_float_r7: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (active == OP_HIGHZ) |-> (pin_oe_o == '0));
  p_clamp_stable_r8: assert property (@(posedge tck_i) disable iff (!rst_ni)
    ((active == OP_CLAMP) && !update_ir_i && !tlr_i) |=> $stable(pin_val_o));
endmodule

// File: tb/jtag_dr_unit_test.sv
`timescale 1ns/1ps
module jtag_dr_unit_test;
  localparam int N    = 8;
  localparam int CH   = 4;
  localparam int REV  = 1;

  logic tck = 1'b0, rst_ni = 1'b0;
  logic tlr = 0, cap = 0, sh = 0, upd = 0, updir = 0, tdi = 0;
  logic [2:0] ins = 3'b010;
  logic [N-1:0] core_val = '0, core_oe = '0, pin_in = '0;
  logic tdo, tdo_oe;
  logic [N-1:0] pin_val, pin_oe;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #4 tck = ~tck;

  jtag_dr_unit #(.NUM_PINS(N), .CHANNELS(CH), .REVISION(4'(REV))) uut (
    .tck_i(tck), .rst_ni(rst_ni), .tlr_i(tlr), .capture_dr_i(cap),
    .shift_dr_i(sh), .update_dr_i(upd), .update_ir_i(updir), .instr_i(ins),
    .tdi_i(tdi), .tdo_o(tdo), .tdo_oe_o(tdo_oe), .core_val_i(core_val),
    .core_oe_i(core_oe), .pin_in_i(pin_in), .pin_val_o(pin_val), .pin_oe_o(pin_oe)
  );

  // behavioural reference: mode as an integer, scan chains as bit queues
  int          m_mode;  // 0 ext 1 sample 2 id 3 hiz 4 clamp 7 bypass
  bit          m_bsr[$];
  bit          m_id[$];
  bit          m_byp;
  logic [N-1:0] m_par;
  logic [31:0] id_exp;
  logic [63:0] got;
  int          got_n;

  function automatic int mode_of(input logic [2:0] c);
    if (c <= 3'd4) return int'(c);
    return 7;
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_mode = 2; m_byp = 0; m_par = '0;
    m_bsr.delete(); m_id.delete();
    for (int i = 0; i < N; i++) m_bsr.push_back(1'b0);
    for (int i = 0; i < 32; i++) m_id.push_back(id_exp[i]);
  endtask

  function automatic bit sel_lsb();
    if (m_mode == 0 || m_mode == 1) return m_bsr[0];
    if (m_mode == 2) return m_id[0];
    return m_byp;
  endfunction

  // one TAP cycle; entered just after a rising edge
  task automatic step(input string tag, input bit t, input bit c, input bit s,
                      input bit u, input bit ui, input logic [2:0] op, input bit d);
    logic [N-1:0] ev, eo;
    tlr = t; cap = c; sh = s; upd = u; updir = ui; ins = op; tdi = d;
    core_val = N'($urandom); core_oe = N'($urandom);
    @(negedge tck); #1;
    check({tag, "/R11 oe"}, 64'(tdo_oe), 64'(s));
    if (s) begin
      check({tag, "/R11 tdo"}, 64'(tdo), 64'(sel_lsb()));
      if (got_n < 64) got[got_n] = tdo;
      got_n++;
    end
    if (m_mode == 0 || m_mode == 4) begin ev = m_par; eo = '1; end
    else if (m_mode == 3) begin ev = core_val; eo = '0; end
    else begin ev = core_val; eo = core_oe; end
    check({tag, " pin_val"}, 64'(pin_val), 64'(ev));
    check({tag, " pin_oe"}, 64'(pin_oe), 64'(eo));
    @(posedge tck);
    if (t) begin m_mode = 2; m_par = '0; end
    else begin
      if (m_mode == 0 || m_mode == 1) begin
        if (c) for (int i = 0; i < N; i++) m_bsr[i] = pin_in[i];
        else if (s) begin void'(m_bsr.pop_front()); m_bsr.push_back(d); end
        else if (u) for (int i = 0; i < N; i++) m_par[i] = m_bsr[i];
      end else if (m_mode == 2) begin
        if (c) for (int i = 0; i < 32; i++) m_id[i] = id_exp[i];
        else if (s) begin void'(m_id.pop_front()); m_id.push_back(d); end
      end else begin
        if (c) m_byp = 0;
        else if (s) m_byp = d;
      end
      if (ui) m_mode = mode_of(op);
    end
    #1;
  endtask

  task automatic idle(input string tag, input int n);
    for (int i = 0; i < n; i++) step(tag, 0, 0, 0, 0, 0, 3'b000, 0);
  endtask

  task automatic load_ir(input string tag, input logic [2:0] op);
    step(tag, 0, 0, 0, 0, 1, op, 0);
    idle(tag, 1);
  endtask

  task automatic scan_dr(input string tag, input int n, input logic [63:0] din);
    got = '0; got_n = 0;
    step(tag, 0, 1, 0, 0, 0, 3'b000, 0);
    for (int i = 0; i < n; i++) step(tag, 0, 0, 1, 0, 0, 3'b000, din[i]);
    step(tag, 0, 0, 0, 1, 0, 3'b000, 0);
    idle(tag, 1);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      finish_run();
    end
  end

  initial begin
    // R9: ID assembled arithmetically from its fields
    id_exp = 32'(REV) * 32'h1000_0000 + (32'h2B + 32'(CH)) * 32'h1000 + 32'h143;
    model_reset();
    #20; @(posedge tck); #1; rst_ni = 1'b1;
    // R6: reset state
    idle("R6 reset", 2);

    // R5, R9: default instruction is IDCODE
    scan_dr("R5 id", 32, 64'h0);
    check("R9 id word", got[31:0], 64'(id_exp));
    check("R9 dev field", 64'(got[27:12]), 64'h002F);

    // R2: sample/preload, pins stay on core
    pin_in = 8'hA5;
    load_ir("R2 sample", 3'b001);
    scan_dr("R2 sample", N, 64'h3C);
    check("R2 captured pins", 64'(got[N-1:0]), 64'hA5);

    // R3, R10: extest drives preloaded value, then new update
    load_ir("R3 extest", 3'b000);
    check("R3 pins driven", 64'(pin_val), 64'h3C);
    pin_in = 8'h5A;
    scan_dr("R3 extest", N, 64'hF0);
    check("R3 captured pins", 64'(got[N-1:0]), 64'h5A);
    check("R10 update", 64'(pin_val), 64'hF0);

    // R4: bypass, one-cycle delay, capture 0
    load_ir("R4 bypass", 3'b111);
    scan_dr("R4 bypass", 12, 64'hB6D);
    check("R4 delayed bits", 64'(got[11:0]), 64'({11'h36D & 11'h7FF, 1'b0}) & 64'hFFF);
    // R10: update-DR under bypass leaves parallel stage alone
    load_ir("R10 back to extest", 3'b000);
    check("R10 hold", 64'(pin_val), 64'hF0);

    // R1: undefined code 101 and 110 act as bypass
    load_ir("R1 code101", 3'b101);
    scan_dr("R1 code101", 4, 64'h9);
    check("R1 code101 path", 64'(got[3:0]), 64'h2);
    load_ir("R1 code110", 3'b110);
    scan_dr("R1 code110", 3, 64'h5);
    // R1: code presented without update-IR has no effect
    step("R1 no update", 0, 0, 0, 0, 0, 3'b011, 0);
    idle("R1 no update", 2);

    // R8: clamp holds, bypass path, update-DR does nothing
    load_ir("R8 clamp", 3'b100);
    check("R8 clamp value", 64'(pin_val), 64'hF0);
    scan_dr("R8 clamp", 5, 64'h16);
    check("R8 bypass path", 64'(got[4:0]), 64'h0C);
    check("R8 still held", 64'(pin_val), 64'hF0);

    // R7: highz floats every pin
    load_ir("R7 highz", 3'b011);
    scan_dr("R7 highz", 6, 64'h2B);
    check("R7 oe", 64'(pin_oe), 64'h0);
    check("R7 bypass path", 64'(got[5:0]), 64'h16);

    // R6: test-logic-reset clears parallel stage, selects IDCODE
    load_ir("R6 pre", 3'b000);
    step("R6 tlr", 1, 0, 0, 0, 0, 3'b000, 0);
    idle("R6 tlr", 1);
    scan_dr("R6 id after tlr", 32, 64'h0);
    check("R6 idcode active", got[31:0], 64'(id_exp));
    load_ir("R6 extest", 3'b000);
    check("R6 cleared", 64'(pin_val), 64'h0);

    done = 1;
    finish_run();
  end
endmodule